// File: doc/BRIEF.md
# Character Display Instruction Engine

This block is the command-execution core of a small character display controller. It accepts one-cycle request pulses from a host bus front end: an instruction write, a data write and a data read. It decodes 8-bit instruction codes and holds the mode flags: entry direction, auto-shift, display, cursor, blink and bus width. It also keeps the address counter, a flag that selects the character-data RAM or the glyph RAM, and the display window offset. It drives two external RAMs through plain address, write-enable and data ports with combinational read data.

Reads are served from a prefetch register. An address load, a cursor move or a data read refills that register from the RAM at the new address. A clear command, and the reset itself, sweep the fill character through every character-data location. The busy output stays high for a fixed number of cycles while this happens. Every request that arrives while busy is high is dropped.

The engine is built around one finite-state machine with three states:
- `ST_CLR` runs the sweep and counts the busy window.
- `ST_IDLE` accepts requests.
- `ST_FETCH` takes one cycle to refill the prefetch register.

The transitions are:
- reset enters `ST_CLR`.
- `ST_CLR` moves to `ST_IDLE` when the busy count reaches its last value.
- `ST_IDLE` moves to `ST_CLR` on an accepted clear.
- `ST_IDLE` moves to `ST_FETCH` on an accepted address load, cursor move or data read.
- `ST_FETCH` always returns to `ST_IDLE`.

Top module: `lcdc_core`

## Requirements
- R1: Instruction code 01h starts a clear. Codes 02h and 03h perform return home. Code 00h changes nothing.
- R2: Return home sets the address counter and the window offset to 0 and selects the character-data RAM. It leaves the RAM contents untouched.
- R3: Code 000001ab sets the entry direction to a (bit 1, 1 = increment) and auto-shift to b (bit 0). Code 00001dcb sets display-on to d (bit 2), cursor-on to c (bit 1) and blink-on to b (bit 0).
- R4: Code 001xxxxx sets the bus-width flag from bit 4 (1 = 8-bit).
- R5: Code 1xxaaaaa selects the character-data RAM and loads the address counter with bits 4:0. Code 01xxaaaa selects the glyph RAM and loads the counter with bits 3:0. Data writes go only to the selected RAM.
- R6: A clear writes 20h to all 32 character-data locations. It sets the address counter and window offset to 0, sets the entry direction to increment and selects the character-data RAM. Busy stays high for exactly 34 cycles after the accepting edge.
- R7: Each accepted data write or data read moves the address counter by +1 when the entry direction is increment, and by -1 otherwise.
- R8: A character-data write with auto-shift set moves the window offset by +1 when the entry direction is increment, and by -1 otherwise. Reads and glyph-RAM writes never move the window.
- R9: Code 0001srxx with s = 0 moves the address counter by -1 (r = 0) or +1 (r = 1). With s = 1 it moves the window offset by +1 (r = 0) or -1 (r = 1) and leaves the counter unchanged.
- R10: After reset all character-data locations hold 20h. The address counter is 0, the entry direction is increment, and auto-shift, display, cursor and blink are 0. The bus width is 8-bit, and busy is high until the sweep ends.
- R11: An address load or cursor move refills the prefetch register from the new address. A data read returns the register and then refills it from the stepped address. A data write does not refill it.
- R12: The address counter wraps modulo 32 while the character-data RAM is selected and modulo 16 while the glyph RAM is selected.
- R13: While busy is high, all requests are ignored. When several arrive in the same idle cycle, an instruction write wins over a data write, and a data write wins over a data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts the init sweep |
| cmd_wr | input | 1 | Instruction write request pulse |
| data_wr | input | 1 | Data write request pulse |
| data_rd | input | 1 | Data read request pulse |
| wr_data | input | 8 | Instruction code or write data |
| rd_data | output | 8 | Value returned by the last accepted data read |
| busy | output | 1 | High while a sweep or prefetch is in progress |
| addr_cnt | output | 5 | Address counter |
| sel_glyph | output | 1 | 1 = glyph RAM selected, 0 = character-data RAM |
| win_ofs | output | 5 | Display window offset |
| entry_inc | output | 1 | Entry direction, 1 = increment |
| entry_shift | output | 1 | Auto-shift on data-RAM writes |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Cursor blink enable |
| bus8 | output | 1 | Bus width, 1 = 8-bit |
| dd_addr | output | 5 | Character-data RAM address |
| dd_we | output | 1 | Character-data RAM write enable |
| dd_wdata | output | 8 | Character-data RAM write data |
| dd_rdata | input | 8 | Character-data RAM read data (combinational) |
| cg_addr | output | 4 | Glyph RAM address |
| cg_we | output | 1 | Glyph RAM write enable |
| cg_wdata | output | 8 | Glyph RAM write data |
| cg_rdata | input | 8 | Glyph RAM read data (combinational) |

## Verification
A wrong address counter shows on `addr_cnt` one cycle after the access that stepped it. It then shows as data landing at the wrong RAM location on the next write. A stale or mis-timed prefetch register appears only at the next data read, so reads follow writes to expose it.

A sweep that ends early or late changes the busy width counted at the port. It can also leave a location without the fill character. A request that leaks through while busy is high shows once busy falls, in the mode outputs or the RAM contents.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_DISP,
        OP_SHIFT,
        OP_FUNC,
        OP_GLYPH_ADDR,
        OP_DATA_ADDR
    } op_e;

    typedef enum logic [1:0] {
        ST_CLR,
        ST_IDLE,
        ST_FETCH
    } st_e;

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
(
    input  logic [7:0] code,
    output op_e        op
);
    // The highest set bit selects the instruction class.
    always_comb begin
        if (code[7])      op = OP_DATA_ADDR;
        else if (code[6]) op = OP_GLYPH_ADDR;
        else if (code[5]) op = OP_FUNC;
        else if (code[4]) op = OP_SHIFT;
        else if (code[3]) op = OP_DISP;
        else if (code[2]) op = OP_ENTRY;
        else if (code[1]) op = OP_HOME;
        else if (code[0]) op = OP_CLEAR;
        else              op = OP_NOP;
    end
endmodule

// File: rtl/lcdc_step.sv
module lcdc_step #(
    parameter int W  = 5,
    parameter int NW = 4
) (
    input  logic [W-1:0] val,
    input  logic         up,
    input  logic         narrow,
    output logic [W-1:0] nxt
);
    logic [W-1:0] raw;
    logic [W-1:0] mask;

    assign raw = up ? val + 1'b1 : val - 1'b1;

    generate
        if (W > NW) begin : g_mask
            assign mask = narrow ? {{(W-NW){1'b0}}, {NW{1'b1}}} : {W{1'b1}};
        end else begin : g_full
            assign mask = {W{1'b1}};
        end
    endgenerate

    assign nxt = raw & mask;
endmodule

// File: rtl/lcdc_core.sv
module lcdc_core
    import lcdc_pkg::*;
#(
    parameter int         DD_DEPTH    = 32,
    parameter int         CG_DEPTH    = 16,
    parameter int         BUSY_CYCLES = 34,
    parameter logic [7:0] FILL_CHAR   = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic [4:0] addr_cnt,
    output logic       sel_glyph,
    output logic [4:0] win_ofs,
    output logic       entry_inc,
    output logic       entry_shift,
    output logic       disp_on,
    output logic       cursor_on,
    output logic       blink_on,
    output logic       bus8,
    output logic [4:0] dd_addr,
    output logic       dd_we,
    output logic [7:0] dd_wdata,
    input  logic [7:0] dd_rdata,
    output logic [3:0] cg_addr,
    output logic       cg_we,
    output logic [7:0] cg_wdata,
    input  logic [7:0] cg_rdata
);
    localparam int AW  = $clog2(DD_DEPTH);
    localparam int CAW = $clog2(CG_DEPTH);
    localparam int CW  = $clog2(BUSY_CYCLES + DD_DEPTH + 1);
    localparam logic [CW-1:0] CNT_LAST  = CW'(BUSY_CYCLES - 1);
    localparam logic [CW-1:0] CNT_SWEEP = CW'(DD_DEPTH);

    st_e           st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    op_e           op;

    logic [AW-1:0] ac_q, ac_nxt, ofs_q, ofs_nxt;
    logic          sel_q, inc_q, sh_q, d_q, c_q, b_q, dl_q;
    logic [7:0]    ofr_q, rd_q;

    logic idle, acc_cmd, acc_wr, acc_rd, shift_cmd, ac_dir, ofs_dir;

    lcdc_decode u_decode (
        .code (wr_data),
        .op   (op)
    );

    assign idle      = (st_q == ST_IDLE);
    assign acc_cmd   = idle && cmd_wr;
    assign acc_wr    = idle && !cmd_wr && data_wr;
    assign acc_rd    = idle && !cmd_wr && !data_wr && data_rd;
    assign shift_cmd = acc_cmd && (op == OP_SHIFT);

    // A cursor move steps by its R/L bit; data accesses follow the entry direction.
    assign ac_dir  = shift_cmd ? wr_data[2] : inc_q;
    // A display shift to the left moves the window start up.
    assign ofs_dir = shift_cmd ? ~wr_data[2] : inc_q;

    lcdc_step #(.W(AW), .NW(CAW)) u_ac_step (
        .val    (ac_q),
        .up     (ac_dir),
        .narrow (sel_q),
        .nxt    (ac_nxt)
    );

    lcdc_step #(.W(AW), .NW(CAW)) u_ofs_step (
        .val    (ofs_q),
        .up     (ofs_dir),
        .narrow (1'b0),
        .nxt    (ofs_nxt)
    );

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = '0;
        unique case (st_q)
            ST_CLR: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) st_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (acc_cmd) begin
                    unique case (op)
                        OP_CLEAR:                   st_d = ST_CLR;
                        OP_DATA_ADDR, OP_GLYPH_ADDR: st_d = ST_FETCH;
                        OP_SHIFT:                   st_d = wr_data[3] ? ST_IDLE : ST_FETCH;
                        default:                    st_d = ST_IDLE;
                    endcase
                end else if (acc_rd) begin
                    st_d = ST_FETCH;
                end
            end
            ST_FETCH: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_CLR;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Mode, address and prefetch registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_q  <= '0;
            sel_q <= 1'b0;
            inc_q <= 1'b1;
            sh_q  <= 1'b0;
            d_q   <= 1'b0;
            c_q   <= 1'b0;
            b_q   <= 1'b0;
            dl_q  <= 1'b1;
            ofs_q <= '0;
            ofr_q <= '0;
            rd_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (acc_cmd) begin
                        unique case (op)
                            OP_CLEAR: begin
                                ac_q  <= '0;
                                ofs_q <= '0;
                                inc_q <= 1'b1;
                                sel_q <= 1'b0;
                            end
                            OP_HOME: begin
                                ac_q  <= '0;
                                ofs_q <= '0;
                                sel_q <= 1'b0;
                            end
                            OP_ENTRY: begin
                                inc_q <= wr_data[1];
                                sh_q  <= wr_data[0];
                            end
                            OP_DISP: begin
                                d_q <= wr_data[2];
                                c_q <= wr_data[1];
                                b_q <= wr_data[0];
                            end
                            OP_SHIFT: begin
                                if (wr_data[3]) ofs_q <= ofs_nxt;
                                else            ac_q  <= ac_nxt;
                            end
                            OP_FUNC: dl_q <= wr_data[4];
                            OP_GLYPH_ADDR: begin
                                sel_q <= 1'b1;
                                ac_q  <= AW'(wr_data[CAW-1:0]);
                            end
                            OP_DATA_ADDR: begin
                                sel_q <= 1'b0;
                                ac_q  <= wr_data[AW-1:0];
                            end
                            default: ;
                        endcase
                    end else if (acc_wr) begin
                        ac_q <= ac_nxt;
                        if (!sel_q && sh_q) ofs_q <= ofs_nxt;
                    end else if (acc_rd) begin
                        rd_q <= ofr_q;
                        ac_q <= ac_nxt;
                    end
                end
                ST_FETCH: ofr_q <= sel_q ? cg_rdata : dd_rdata;
                default: ;
            endcase
        end
    end

    // RAM ports
    always_comb begin
        if (st_q == ST_CLR) begin
            dd_addr  = cnt_q[AW-1:0];
            dd_we    = (cnt_q < CNT_SWEEP);
            dd_wdata = FILL_CHAR;
        end else begin
            dd_addr  = ac_q;
            dd_we    = acc_wr && !sel_q;
            dd_wdata = wr_data;
        end
        cg_addr  = ac_q[CAW-1:0];
        cg_we    = acc_wr && sel_q;
        cg_wdata = wr_data;
    end

    assign busy        = !idle;
    assign addr_cnt    = ac_q;
    assign sel_glyph   = sel_q;
    assign win_ofs     = ofs_q;
    assign entry_inc   = inc_q;
    assign entry_shift = sh_q;
    assign disp_on     = d_q;
    assign cursor_on   = c_q;
    assign blink_on    = b_q;
    assign bus8        = dl_q;
    assign rd_data     = rd_q;

    AST_ONE_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dd_we && cg_we)); // R5
    AST_SWEEP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (dd_we && busy) |-> dd_wdata == FILL_CHAR); // R6
    AST_SWEEP_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CLR) |-> (ac_q == '0 && ofs_q == '0 && inc_q && !sel_q)); // R6
    AST_READ_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && inc_q && !sel_q) |=> ac_q == AW'($past(ac_q) + 1'b1)); // R7
    AST_READ_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> $stable(ofs_q)); // R8
    AST_GLYPH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |-> ac_q[AW-1:CAW] == '0); // R12
    AST_FETCH_BRIEF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FETCH) |=> (st_q == ST_IDLE)); // R11
    AST_BUSY_NO_GLYPH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cg_we); // R13
endmodule

// File: tb/lcdc_core_bench.sv
module lcdc_core_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       busy, sel_glyph, entry_inc, entry_shift, disp_on, cursor_on, blink_on, bus8;
    logic [4:0] addr_cnt, win_ofs, dd_addr;
    logic       dd_we, cg_we;
    logic [7:0] dd_wdata, dd_rdata, cg_wdata, cg_rdata;
    logic [3:0] cg_addr;
    logic [7:0] dd_mem [32];
    logic [7:0] cg_mem [16];

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdc_core u_lcdc_core (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr), .data_rd(data_rd),
        .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .addr_cnt(addr_cnt),
        .sel_glyph(sel_glyph), .win_ofs(win_ofs), .entry_inc(entry_inc),
        .entry_shift(entry_shift), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .bus8(bus8), .dd_addr(dd_addr), .dd_we(dd_we),
        .dd_wdata(dd_wdata), .dd_rdata(dd_rdata), .cg_addr(cg_addr), .cg_we(cg_we),
        .cg_wdata(cg_wdata), .cg_rdata(cg_rdata)
    );

    always @(posedge clk) begin
        if (dd_we) dd_mem[dd_addr] <= dd_wdata;
        if (cg_we) cg_mem[cg_addr] <= cg_wdata;
    end
    assign dd_rdata = dd_mem[dd_addr];
    assign cg_rdata = cg_mem[cg_addr];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] code);
        @(negedge clk); cmd_wr = 1'b1; wr_data = code;
        @(negedge clk); cmd_wr = 1'b0;
        wait_idle();
    endtask

    task automatic write_byte(input logic [7:0] v);
        @(negedge clk); data_wr = 1'b1; wr_data = v;
        @(negedge clk); data_wr = 1'b0;
        wait_idle();
    endtask

    task automatic read_byte(output logic [7:0] v);
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0; v = rd_data;
        wait_idle();
    endtask

    task automatic check_fill(input string req);
        int bad = 0;
        for (int i = 0; i < 32; i++) if (dd_mem[i] !== 8'h20) bad++;
        check(req, bad, 0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) dd_mem[i] = 8'hA5;
        for (int i = 0; i < 16; i++) cg_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R10 busy during reset", busy, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 busy after release", busy, 1);
        wait_idle();
        check_fill("R10 fill");
        check("R10 ac", addr_cnt, 0);
        check("R10 modes", {entry_inc, entry_shift, disp_on, cursor_on, blink_on, bus8}, 6'b100001);
    endtask

    task automatic t_write_step();
        logic [7:0] v;
        send_cmd(8'h85);
        check("R5 data addr load", {sel_glyph, addr_cnt}, 6'h05);
        write_byte(8'h41);
        write_byte(8'h42);
        check("R7 inc write", addr_cnt, 7);
        check("R5 data ram written", {dd_mem[5], dd_mem[6]}, 16'h4142);
        send_cmd(8'h04);
        check("R3 entry dec", {entry_inc, entry_shift}, 2'b00);
        write_byte(8'h43);
        check("R7 dec write", addr_cnt, 6);
        send_cmd(8'h80);
        write_byte(8'h44);
        check("R12 wrap 32", addr_cnt, 31);
        v = 8'h00;
    endtask

    task automatic t_prefetch();
        logic [7:0] v;
        send_cmd(8'h06);
        send_cmd(8'h85);
        read_byte(v);
        check("R11 read after addr load", v, 8'h41);
        check("R7 inc read", addr_cnt, 6);
        read_byte(v);
        check("R11 read refill", v, 8'h42);
        write_byte(8'h5A);
        read_byte(v);
        check("R11 write does not refill", v, 8'h43);
    endtask

    task automatic t_autoshift();
        logic [7:0] v;
        send_cmd(8'h07);
        send_cmd(8'h8A);
        write_byte(8'h78);
        check("R8 shift left on write", {win_ofs, addr_cnt}, {5'd1, 5'd11});
        send_cmd(8'h05);
        write_byte(8'h79);
        check("R8 shift right on write", {win_ofs, addr_cnt}, {5'd0, 5'd10});
        read_byte(v);
        check("R8 no shift on read", {win_ofs, addr_cnt}, {5'd0, 5'd9});
        send_cmd(8'h40);
        write_byte(8'h11);
        check("R8 no shift on glyph write", win_ofs, 0);
        check("R12 wrap 16", {sel_glyph, addr_cnt}, 6'h2F);
        check("R5 glyph ram written", cg_mem[0], 8'h11);
    endtask

    task automatic t_shift_cmd();
        send_cmd(8'h06);
        send_cmd(8'h85);
        send_cmd(8'h10);
        check("R9 cursor left", addr_cnt, 4);
        send_cmd(8'h14);
        check("R9 cursor right", addr_cnt, 5);
        send_cmd(8'h18);
        check("R9 display left", {win_ofs, addr_cnt}, {5'd1, 5'd5});
        send_cmd(8'h1C);
        check("R9 display right", {win_ofs, addr_cnt}, {5'd0, 5'd5});
    endtask

    task automatic t_modes();
        send_cmd(8'h0F);
        check("R3 disp all on", {disp_on, cursor_on, blink_on}, 3'b111);
        send_cmd(8'h0A);
        check("R3 disp mix", {disp_on, cursor_on, blink_on}, 3'b010);
        send_cmd(8'h20);
        check("R4 bus 4", bus8, 0);
        send_cmd(8'h30);
        check("R4 bus 8", bus8, 1);
    endtask

    task automatic t_glyph();
        logic [7:0] v;
        send_cmd(8'h4F);
        check("R5 glyph addr load", {sel_glyph, addr_cnt}, 6'h2F);
        write_byte(8'h1F);
        check("R12 glyph wrap up", addr_cnt, 0);
        send_cmd(8'h4F);
        read_byte(v);
        check("R11 glyph read", v, 8'h1F);
    endtask

    task automatic t_home();
        send_cmd(8'h87);
        send_cmd(8'h18);
        send_cmd(8'h02);
        check("R2 home 02", {sel_glyph, win_ofs, addr_cnt}, 11'd0);
        check("R2 ram untouched", dd_mem[5], 8'h41);
        send_cmd(8'h83);
        send_cmd(8'h03);
        check("R1 home 03", addr_cnt, 0);
        send_cmd(8'h85);
        send_cmd(8'h00);
        check("R1 nop", {addr_cnt, disp_on, cursor_on, blink_on}, {5'd5, 3'b010});
    endtask

    task automatic t_clear_busy();
        int n = 0;
        send_cmd(8'h04);
        send_cmd(8'h18);
        send_cmd(8'h08);
        @(negedge clk); cmd_wr = 1'b1; wr_data = 8'h01;
        @(negedge clk); cmd_wr = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (busy) n++;
            data_wr = (i == 1);
            cmd_wr  = (i == 2);
            wr_data = (i == 1) ? 8'h55 : 8'h0F;
            @(negedge clk);
        end
        cmd_wr = 1'b0; data_wr = 1'b0;
        check("R6 busy width", n, 34);
        check_fill("R6 fill");
        check("R6 state", {win_ofs, addr_cnt, entry_inc}, {5'd0, 5'd0, 1'b1});
        check("R13 ignored while busy", {disp_on, cursor_on, blink_on}, 3'b000);
        @(negedge clk); cmd_wr = 1'b1; data_wr = 1'b1; wr_data = 8'h0F;
        @(negedge clk); cmd_wr = 1'b0; data_wr = 1'b0;
        wait_idle();
        check("R13 cmd wins", {disp_on, addr_cnt, dd_mem[0]}, {1'b1, 5'd0, 8'h20});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_write_step();
        t_prefetch();
        t_autoshift();
        t_shift_cmd();
        t_modes();
        t_glyph();
        t_home();
        t_clear_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule